// File: doc/BRIEF.md
# Light-Load Frequency Foldback Controller

This block sets the switching period and the peak-current setpoint of a peak-current-mode converter from a sampled, unsigned feedback code. At heavy load it runs at a nominal period, which is one of two values picked by a select input. As the feedback code falls, the period stretches linearly toward a floor period. Further down, the setpoint stops following feedback and is pinned. Below that, a skip flag with hysteresis tells the pulse generator to drop pulses. All thresholds and period counts are parameters.

The block also contains the switching-cycle timer. It counts out each cycle and marks cycle starts. At each start it loads the period that the next cycle will use, and nowhere else, so a cycle already running is never shortened or stretched. The applied period is the base period plus a triangular jitter offset that moves by one count per switching cycle. The jitter stays active throughout foldback and at the floor.

Top module: `fold_ctrl`

## Requirements
- R1: When `fb_code` is above `TH_START` (160), `period` equals the nominal count one clock after the code is presented: `PER_FAST` (100) when `fast_sel` is 1, or `PER_SLOW` (154) when `fast_sel` is 0.
- R2: When `fb_code` is at or below `TH_START` and above `TH_END` (96), `period` equals nominal + ((`PER_FLOOR` − nominal) · (`TH_START` − fb)) / (`TH_START` − `TH_END`), using integer division that truncates. The result is due one clock later.
- R3: When `fb_code` is at or below `TH_END`, `period` equals `PER_FLOOR` (400) one clock later.
- R4: `setpoint` equals `fb_code` while the code is above `TH_FREEZE` (64). At or below `TH_FREEZE` it holds the value `TH_FREEZE`. The result is due one clock later.
- R5: `skip` sets one clock after `fb_code` is below `TH_SKIP` (40). It clears one clock after the code is at or above `TH_SKIP + SKIP_HYST` (48). For codes in between, it keeps its previous value.
- R6: `cyc_start` is a one-clock pulse. Take the clock on which one pulse is seen: the next pulse comes exactly `jit_period` clocks later, where `jit_period` is the value shown one clock after that pulse. `jit_period` changes only on the edge that ends a `cyc_start` clock.
- R7: On the edge that ends each `cyc_start` clock, `jit_period` loads `period` + offset. The offset starts at 0 and rises, changes by one per cycle start, and reverses direction after it reaches +`JIT_AMP` or −`JIT_AMP` (3). This applies in every region, including foldback and the floor.
- R8: While `rst_n` is low, `period`, `setpoint`, `jit_period` and `skip` are 0 and `cyc_start` is 0. The first `cyc_start` is seen in the first clock after the first rising edge following reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_code | input | FB_W (8) | Sampled feedback code |
| fast_sel | input | 1 | Nominal-rate select: 1 for the higher rate, 0 for the lower rate |
| period | output | PER_W (10) | Base period count before jitter |
| setpoint | output | FB_W (8) | Peak-current setpoint code |
| skip | output | 1 | Pulse-suppression flag |
| jit_period | output | PER_W (10) | Period applied to the current switching cycle |
| cyc_start | output | 1 | High for the first clock of each switching cycle |

## Verification
`period`, `setpoint` and `skip` are each one register away from `fb_code`. The bench therefore drives a code on a falling edge, lets one rising edge pass and samples on the next falling edge. It sweeps every code upward and then downward for both nominal rates, so the hysteresis band is entered from each side. `jit_period` is loaded on the rising edge that ends a `cyc_start` clock, so it is sampled on the falling edge after the one that showed the pulse. The interval check counts falling edges between consecutive pulses. The jitter model steps on every pulse from reset onward and is compared only after the feedback code has been held steady for several clocks.

// File: rtl/fold_pkg.sv
// Shared types for the foldback controller.
package fold_pkg;
    // Operating region decoded from the feedback code, highest load first.
    typedef enum logic [1:0] {
        RG_NOMINAL = 2'd0,
        RG_FOLD    = 2'd1,
        RG_FLOOR   = 2'd2,
        RG_FROZEN  = 2'd3
    } region_e;
endpackage

// File: rtl/fold_map.sv
// Combinational map from feedback code to target period and setpoint.
// Assumes TH_START > TH_END > TH_FREEZE and PER_FLOOR >= both nominal counts.
module fold_map #(
    parameter int FB_W      = 8,
    parameter int PER_W     = 10,
    parameter int TH_START  = 160,
    parameter int TH_END    = 96,
    parameter int TH_FREEZE = 64,
    parameter int PER_SLOW  = 154,
    parameter int PER_FAST  = 100,
    parameter int PER_FLOOR = 400
) (
    input  logic [FB_W-1:0]  fb,
    input  logic             fast_sel,
    output logic [PER_W-1:0] per_tgt,
    output logic [FB_W-1:0]  set_tgt,
    output fold_pkg::region_e region
);
    import fold_pkg::*;

    localparam int SPAN = TH_START - TH_END;
    localparam logic [FB_W-1:0] TS = FB_W'(TH_START);
    localparam logic [FB_W-1:0] TE = FB_W'(TH_END);
    localparam logic [FB_W-1:0] TF = FB_W'(TH_FREEZE);

    int nom_i;
    int lift_i;

    // Decode the region from the thresholds.
    always_comb begin
        if (fb > TS)       region = RG_NOMINAL;
        else if (fb > TE)  region = RG_FOLD;
        else if (fb > TF)  region = RG_FLOOR;
        else               region = RG_FROZEN;
    end

    // Pick the target period: nominal, interpolated, or floor.
    always_comb begin
        nom_i  = fast_sel ? PER_FAST : PER_SLOW;
        lift_i = ((PER_FLOOR - nom_i) * (TH_START - int'(fb))) / SPAN;
        case (region)
            RG_NOMINAL: per_tgt = PER_W'(nom_i);
            RG_FOLD:    per_tgt = PER_W'(nom_i + lift_i);
            default:    per_tgt = PER_W'(PER_FLOOR);
        endcase
    end

    // Setpoint tracks feedback until the freeze point.
    always_comb begin
        set_tgt = (region == RG_FROZEN) ? TF : fb;
    end
endmodule

// File: rtl/skip_hyst.sv
// Skip flag with hysteresis. Assumes TH_SKIP + HYST fits in FB_W bits.
module skip_hyst #(
    parameter int FB_W    = 8,
    parameter int TH_SKIP = 40,
    parameter int HYST    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FB_W-1:0] fb,
    output logic            skip
);
    localparam logic [FB_W-1:0] LO = FB_W'(TH_SKIP);
    localparam logic [FB_W-1:0] HI = FB_W'(TH_SKIP + HYST);

    // Set below the low threshold, clear at or above the high one, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        skip <= 1'b0;
        else if (fb < LO)  skip <= 1'b1;
        else if (fb >= HI) skip <= 1'b0;
    end
endmodule

// File: rtl/jitter_tri.sv
// Triangular jitter offset, stepped once per switching cycle.
// Assumes AMP is well below the smallest period.
module jitter_tri #(
    parameter int AMP   = 3,
    parameter int OFF_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    output logic signed [OFF_W-1:0] off
);
    generate
        if (AMP == 0) begin : g_off
            // Jitter disabled: offset is always zero.
            assign off = '0;
        end else begin : g_on
            localparam logic signed [OFF_W-1:0] PK = OFF_W'(AMP);
            logic up;
            // Move the offset one count per cycle and turn at the peaks.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    off <= '0;
                    up  <= 1'b1;
                end else if (step) begin
                    if (up) begin
                        if (off == PK) begin
                            up  <= 1'b0;
                            off <= off - 1'b1;
                        end else begin
                            off <= off + 1'b1;
                        end
                    end else begin
                        if (off == -PK) begin
                            up  <= 1'b1;
                            off <= off + 1'b1;
                        end else begin
                            off <= off - 1'b1;
                        end
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/cycle_timer.sv
// Switching-cycle timer. Loads base + jitter only at a cycle start.
// Assumes base + offset stays at or above 2 once running.
module cycle_timer #(
    parameter int PER_W = 10,
    parameter int OFF_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PER_W-1:0]        base,
    input  logic signed [OFF_W-1:0] off,
    output logic                    cyc_start,
    output logic [PER_W-1:0]        applied
);
    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] load;

    // Sum base and signed offset.
    always_comb begin
        load = PER_W'(int'(base) + int'(off));
    end

    assign cyc_start = rst_n && (cnt == '0);

    // Count the cycle down; reload at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= PER_W'(1);
            applied <= '0;
        end else if (cnt == '0) begin
            cnt     <= load - 1'b1;
            applied <= load;
        end else begin
            cnt     <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/fold_ctrl.sv
// Light-load foldback controller top. It registers the mapped period and
// setpoint, runs skip hysteresis, jitter and the cycle timer.
// Assumes fb_code is already synchronous to clk.
module fold_ctrl #(
    parameter int FB_W      = 8,
    parameter int PER_W     = 10,
    parameter int TH_START  = 160,
    parameter int TH_END    = 96,
    parameter int TH_FREEZE = 64,
    parameter int TH_SKIP   = 40,
    parameter int SKIP_HYST = 8,
    parameter int PER_SLOW  = 154,
    parameter int PER_FAST  = 100,
    parameter int PER_FLOOR = 400,
    parameter int JIT_AMP   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FB_W-1:0]  fb_code,
    input  logic             fast_sel,
    output logic [PER_W-1:0] period,
    output logic [FB_W-1:0]  setpoint,
    output logic             skip,
    output logic [PER_W-1:0] jit_period,
    output logic             cyc_start
);
    localparam int OFF_W = $clog2(JIT_AMP + 1) + 1;

    logic [PER_W-1:0]        per_tgt;
    logic [FB_W-1:0]         set_tgt;
    fold_pkg::region_e       region;
    logic signed [OFF_W-1:0] off;

    fold_map #(
        .FB_W(FB_W), .PER_W(PER_W), .TH_START(TH_START), .TH_END(TH_END),
        .TH_FREEZE(TH_FREEZE), .PER_SLOW(PER_SLOW), .PER_FAST(PER_FAST),
        .PER_FLOOR(PER_FLOOR)
    ) u_map (
        .fb(fb_code), .fast_sel(fast_sel), .per_tgt(per_tgt),
        .set_tgt(set_tgt), .region(region)
    );

    // Register the mapped period and setpoint.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period   <= '0;
            setpoint <= '0;
        end else begin
            period   <= per_tgt;
            setpoint <= set_tgt;
        end
    end

    skip_hyst #(.FB_W(FB_W), .TH_SKIP(TH_SKIP), .HYST(SKIP_HYST)) u_skip (
        .clk(clk), .rst_n(rst_n), .fb(fb_code), .skip(skip)
    );

    jitter_tri #(.AMP(JIT_AMP), .OFF_W(OFF_W)) u_jit (
        .clk(clk), .rst_n(rst_n), .step(cyc_start), .off(off)
    );

    cycle_timer #(.PER_W(PER_W), .OFF_W(OFF_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .base(period), .off(off),
        .cyc_start(cyc_start), .applied(jit_period)
    );
endmodule

// File: rtl/fold_ctrl_chk.sv
// Assertion checker for fold_ctrl, attached with bind.
module fold_ctrl_chk #(
    parameter int FB_W      = 8,
    parameter int PER_W     = 10,
    parameter int TH_START  = 160,
    parameter int TH_END    = 96,
    parameter int TH_FREEZE = 64,
    parameter int TH_SKIP   = 40,
    parameter int SKIP_HYST = 8,
    parameter int PER_FAST  = 100,
    parameter int PER_FLOOR = 400,
    parameter int JIT_AMP   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [FB_W-1:0]  fb_code,
    input logic             fast_sel,
    input logic [PER_W-1:0] period,
    input logic [FB_W-1:0]  setpoint,
    input logic             skip,
    input logic [PER_W-1:0] jit_period,
    input logic             cyc_start
);
    a_r1_fast_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fb_code) > TH_START && fast_sel) |=> (int'(period) == PER_FAST));
    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fb_code) <= TH_END) |=> (int'(period) == PER_FLOOR));
    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fb_code) <= TH_FREEZE) |=> (int'(setpoint) == TH_FREEZE));
    a_r5_skip_set: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fb_code) < TH_SKIP) |=> skip);
    a_r5_skip_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(fb_code) >= TH_SKIP + SKIP_HYST) |=> !skip);
    a_r6_hold_period: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start |=> $stable(jit_period));
    a_r7_jitter_band: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> ((int'(jit_period) - int'($past(period)) <= JIT_AMP) &&
                       (int'($past(period)) - int'(jit_period) <= JIT_AMP)));
endmodule

bind fold_ctrl fold_ctrl_chk #(
    .FB_W(FB_W), .PER_W(PER_W), .TH_START(TH_START), .TH_END(TH_END),
    .TH_FREEZE(TH_FREEZE), .TH_SKIP(TH_SKIP), .SKIP_HYST(SKIP_HYST),
    .PER_FAST(PER_FAST), .PER_FLOOR(PER_FLOOR), .JIT_AMP(JIT_AMP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .fast_sel(fast_sel),
    .period(period), .setpoint(setpoint), .skip(skip),
    .jit_period(jit_period), .cyc_start(cyc_start)
);

// File: tb/test_fold_ctrl.sv
module test_fold_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fb_code = 8'd0;
    logic       fast_sel = 1'b0;
    logic [9:0] period, jit_period;
    logic [7:0] setpoint;
    logic       skip, cyc_start;

    int errors = 0;
    int checks = 0;
    bit mon_on = 0;
    bit jchk = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fold_ctrl i_fold_ctrl (
        .clk(clk), .rst_n(rst_n), .fb_code(fb_code), .fast_sel(fast_sel),
        .period(period), .setpoint(setpoint), .skip(skip),
        .jit_period(jit_period), .cyc_start(cyc_start)
    );

    function automatic int exp_period(int fb, bit fs);
        int nom = fs ? 100 : 154;
        if (fb > 160) return nom;
        if (fb > 96) return nom + ((400 - nom) * (160 - fb)) / 64;
        return 400;
    endfunction

    function automatic int exp_set(int fb);
        return (fb > 64) ? fb : 64;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Cycle monitor: interval (R6) and jitter sequence (R7).
    int ncyc = 0, prev_n = 0, prev_jp = 0, pend = 0, joff = 0;
    bit jup = 1, have_prev = 0, grab = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            ncyc++;
            if (grab) begin
                prev_jp = jit_period;
                if (jchk) chk("R7 jitter period", jit_period, pend);
                grab = 0;
            end
            if (cyc_start) begin
                if (have_prev) chk("R6 cycle interval", ncyc - prev_n, prev_jp);
                have_prev = 1;
                prev_n = ncyc;
                grab = 1;
                pend = exp_period(fb_code, fast_sel) + joff;
                if (jup) begin
                    if (joff == 3) begin jup = 0; joff--; end else joff++;
                end else begin
                    if (joff == -3) begin jup = 1; joff++; end else joff--;
                end
            end
        end
    end

    // Watchdog.
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=150000", wd);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic sweep(bit fs);
        bit sk;
        sk = skip;
        fast_sel = fs;
        for (int d = 0; d < 2; d++) begin
            for (int k = 0; k < 256; k++) begin
                int v;
                v = (d == 0) ? k : 255 - k;
                fb_code = 8'(v);
                @(posedge clk);
                @(negedge clk);
                if (v > 160) chk("R1 nominal period", period, exp_period(v, fs));
                else if (v > 96) chk("R2 fold period", period, exp_period(v, fs));
                else chk("R3 floor period", period, 400);
                chk("R4 setpoint", setpoint, exp_set(v));
                if (v < 40) sk = 1;
                else if (v >= 48) sk = 0;
                chk("R5 skip", skip, int'(sk));
            end
        end
    endtask

    task automatic jit_phase(int fb, bit fs, int starts);
        fb_code = 8'(fb);
        fast_sel = fs;
        repeat (3) @(negedge clk);
        jchk = 1;
        for (int n = 0; n < starts; n++) begin
            @(negedge clk);
            while (!cyc_start) @(negedge clk);
        end
        @(negedge clk);
        jchk = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 reset period", period, 0);
        chk("R8 reset setpoint", setpoint, 0);
        chk("R8 reset jit_period", jit_period, 0);
        chk("R8 reset skip", skip, 0);
        chk("R8 reset cyc_start", cyc_start, 0);
        fb_code = 8'd200;
        fast_sel = 1'b1;
        rst_n = 1'b1;
        mon_on = 1;
        @(negedge clk);
        chk("R8 first cycle start", cyc_start, 1);
        @(negedge clk);
        chk("R7 first applied period", jit_period, 100);
        sweep(1'b1);
        sweep(1'b0);
        jit_phase(200, 1'b1, 16);
        jit_phase(120, 1'b0, 16);
        jit_phase(20, 1'b1, 16);
        jit_phase(250, 1'b0, 10);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule